// File: doc/BRIEF.md
# Key-Protected Down-Counting Watchdog

The block is a watchdog timer that runs from a slow tick input and drives a reset-request output when its count runs out. A small synchronous register bus reaches four registers: a key register, a divider-select register, a reload register and a status register. The block acts on the key register only when a write carries one of four 16-bit codes. These codes open and close configuration access, start the timer and refresh the count. Any other code does nothing.

Configuration changes reach the running logic only after a fixed number of slow ticks. This models the transfer into a separate low-speed domain. While a transfer is pending, a busy flag in the status register stays set. Once the timer is started, only a system reset stops it. Firmware must write the refresh code before the count reaches zero, or the block raises a one-cycle reset request.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, rst_req_o is 0 and status reads 0. The divider-select register reads 0 and the reload register reads 0xFFF. A read of the key register (address 0) always returns 0.
- R2: While access is locked, writes to the divider-select register (address 1) and to the reload register (address 2) are dropped. Status stays 0 and the readback values do not change. Access is locked after reset and again after key 0x0000 is written.
- R3: Key 0x5555 unlocks access. A write to address 1 then sets status bit 0, and a write to address 2 sets status bit 1.
- R4: A pending update becomes visible, and its busy bit clears, on the SYNC_TICKS-th slow tick after the write. Address 1 reads back the 3-bit code and address 2 reads back the 12-bit value.
- R5: Key 0xCCCC starts the timer and loads the counter from the reload value. The first reset request is a single-cycle pulse on rst_req_o, and it comes max(reload,1) x divider slow ticks after the start. A reload of 0 therefore expires after one divided period.
- R6: The divider code sets the tick division: 0=/4, 1=/8, 2=/16, 3=/32, 4=/64, 5=/128, and 6 or 7=/256.
- R7: Key 0xAAAA, written while the timer runs, reloads the counter and restarts the divider phase. The next request comes max(reload,1) x divider ticks after the refresh.
- R8: After a start, writing keys 0x0000, 0x5555, 0xCCCC or any other code neither stops the timer nor shifts the timing of its requests.
- R9: A key value other than 0x5555, 0x0000, 0xAAAA and 0xCCCC has no effect. For example, writing 0x1234 leaves access locked.
- R10: After each expiry the counter reloads by itself. Requests repeat every max(reload,1) x divider ticks until the next refresh.
- R11: No reset request is raised before the timer has been started, however many ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle slow tick strobe |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address: 0 key, 1 divider, 2 reload, 3 status |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the current address |
| rst_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
The bench builds the block with SYNC_TICKS set to 2, so the window in which a busy flag is still set can be checked on a single tick. Counter and divider widths keep their defaults. Small reload values, including 0, keep every divider code, up to /256, short enough to run to expiry several times. Each run starts from a fresh reset, because a started timer cannot be stopped.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_OPEN    = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_CLOSE   = 16'h0000;
  localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_GO      = 16'hCCCC;

  typedef enum logic [1:0] {
    A_KEY    = 2'd0,
    A_DIV    = 2'd1,
    A_RELOAD = 2'd2,
    A_STAT   = 2'd3
  } wdt_addr_e;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             key_wr_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             unlocked_o,
  output logic             running_o,
  output logic             load_o
);
  logic unlocked_q, unlocked_d;
  logic running_q, running_d;

  always_comb begin
    unlocked_d = unlocked_q;
    running_d  = running_q;
    if (key_wr_i) begin
      if (key_i == KEY_OPEN)  unlocked_d = 1'b1;
      if (key_i == KEY_CLOSE) unlocked_d = 1'b0;
      if (key_i == KEY_GO)    running_d  = 1'b1;
    end
  end

  // start loads the counter once; refresh only matters while running
  assign load_o = key_wr_i && (((key_i == KEY_GO) && !running_q) ||
                               ((key_i == KEY_REFRESH) && running_q));

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_q <= 1'b0;
      running_q  <= 1'b0;
    end else begin
      unlocked_q <= unlocked_d;
      running_q  <= running_d;
    end
  end

  assign unlocked_o = unlocked_q;
  assign running_o  = running_q;
endmodule

// File: rtl/wdt_cfg_sync.sv
module wdt_cfg_sync #(
  parameter int          W          = 12,
  parameter logic [W-1:0] RST_VAL   = '0,
  parameter int          SYNC_TICKS = 3
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         tick_i,
  output logic [W-1:0] active_o,
  output logic         busy_o
);
  localparam int DW = $clog2(SYNC_TICKS + 1);
  localparam logic [DW-1:0] LAST = DW'(SYNC_TICKS - 1);

  logic [W-1:0]  pend_q, pend_d, act_q, act_d;
  logic          busy_q, busy_d;
  logic [DW-1:0] dly_q, dly_d;

  always_comb begin
    pend_d = pend_q;
    act_d  = act_q;
    busy_d = busy_q;
    dly_d  = dly_q;
    if (wr_i) begin
      pend_d = wdata_i;
      busy_d = 1'b1;
      dly_d  = '0;
    end else if (busy_q && tick_i) begin
      if (dly_q == LAST) begin
        act_d  = pend_q;
        busy_d = 1'b0;
      end else begin
        dly_d = dly_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= RST_VAL;
      act_q  <= RST_VAL;
      busy_q <= 1'b0;
      dly_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      busy_q <= busy_d;
      dly_q  <= dly_d;
    end
  end

  assign active_o = act_q;
  assign busy_o   = busy_q;
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W     = 3,
  parameter int MIN_SHIFT = 2,
  parameter int MAX_SHIFT = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [PRE_W-1:0] code_i,
  output logic             cnt_tick_o
);
  localparam int SW = $clog2(MAX_SHIFT + 1);

  logic [MAX_SHIFT-1:0] pcnt_q, pcnt_d, limit;
  logic [SW-1:0]        shift;

  always_comb begin
    if (int'(code_i) + MIN_SHIFT >= MAX_SHIFT) shift = SW'(MAX_SHIFT);
    else                                      shift = SW'(int'(code_i) + MIN_SHIFT);
    limit = MAX_SHIFT'(({{MAX_SHIFT{1'b0}}, 1'b1} << shift) - 1'b1);
  end

  assign cnt_tick_o = run_i && !clear_i && tick_i && (pcnt_q == limit);

  always_comb begin
    pcnt_d = pcnt_q;
    if (!run_i || clear_i)  pcnt_d = '0;
    else if (cnt_tick_o)    pcnt_d = '0;
    else if (tick_i)        pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pcnt_q <= '0;
    else         pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/wdt_downcnt.sv
module wdt_downcnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             cnt_tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             req_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;

  always_comb begin
    cnt_d = cnt_q;
    req_d = 1'b0;
    if (load_i) begin
      cnt_d = reload_i;
    end else if (cnt_tick_i) begin
      if (cnt_q <= CNT_W'(1)) begin
        cnt_d = reload_i;
        req_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int PRE_W      = 3,
  parameter int SYNC_TICKS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        bus_sel_i,
  input  logic        bus_we_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [15:0] bus_wdata_i,
  output logic [15:0] bus_rdata_o,
  output logic        rst_req_o
);
  logic [1:0] rs_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  logic wr, key_wr, div_try, rl_try;
  logic unlocked, running, load, cnt_tick;
  logic div_busy, rl_busy;
  logic [PRE_W-1:0] div_code;
  logic [CNT_W-1:0] reload_val;

  assign wr      = bus_sel_i && bus_we_i;
  assign key_wr  = wr && (bus_addr_i == A_KEY);
  assign div_try = wr && (bus_addr_i == A_DIV);
  assign rl_try  = wr && (bus_addr_i == A_RELOAD);

  wdt_ctrl u_ctrl (
    .clk(clk), .rst_ni(rst_ni), .key_wr_i(key_wr), .key_i(bus_wdata_i),
    .unlocked_o(unlocked), .running_o(running), .load_o(load)
  );

  wdt_cfg_sync #(.W(PRE_W), .RST_VAL('0), .SYNC_TICKS(SYNC_TICKS)) u_div_sync (
    .clk(clk), .rst_ni(rst_ni), .wr_i(div_try && unlocked),
    .wdata_i(bus_wdata_i[PRE_W-1:0]), .tick_i(tick_i),
    .active_o(div_code), .busy_o(div_busy)
  );

  wdt_cfg_sync #(.W(CNT_W), .RST_VAL('1), .SYNC_TICKS(SYNC_TICKS)) u_rl_sync (
    .clk(clk), .rst_ni(rst_ni), .wr_i(rl_try && unlocked),
    .wdata_i(bus_wdata_i[CNT_W-1:0]), .tick_i(tick_i),
    .active_o(reload_val), .busy_o(rl_busy)
  );

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_ni(rst_ni), .tick_i(tick_i), .run_i(running),
    .clear_i(load), .code_i(div_code), .cnt_tick_o(cnt_tick)
  );

  wdt_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_ni(rst_ni), .load_i(load), .cnt_tick_i(cnt_tick),
    .reload_i(reload_val), .req_o(rst_req_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_DIV:    bus_rdata_o = 16'(div_code);
      A_RELOAD: bus_rdata_o = 16'(reload_val);
      A_STAT:   bus_rdata_o = {14'b0, rl_busy, div_busy};
      default:  bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_checks.sv
module wdt_checks (
  input logic clk,
  input logic rst_ni,
  input logic tick_i,
  input logic div_try_i,
  input logic rl_try_i,
  input logic unlocked_i,
  input logic running_i,
  input logic div_busy_i,
  input logic rl_busy_i,
  input logic req_i
);
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    req_i |=> !req_i);

  assert_no_req_idle_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    req_i |-> running_i);

  assert_run_sticky_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    running_i |=> running_i);

  assert_locked_div_drop_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (div_try_i && !unlocked_i && !div_busy_i) |=> !div_busy_i);

  assert_locked_rl_drop_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (rl_try_i && !unlocked_i && !rl_busy_i) |=> !rl_busy_i);

  assert_div_done_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(div_busy_i) |-> $past(tick_i));

  assert_rl_done_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(rl_busy_i) |-> $past(tick_i));
endmodule

bind keyed_wdt wdt_checks u_chk (
  .clk(clk), .rst_ni(rst_ni), .tick_i(tick_i), .div_try_i(div_try),
  .rl_try_i(rl_try), .unlocked_i(unlocked), .running_i(running),
  .div_busy_i(div_busy), .rl_busy_i(rl_busy), .req_i(rst_req_o)
);

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;
  logic        clk;
  logic        rst_n;
  logic        tick_i;
  logic        bus_sel_i, bus_we_i;
  logic [1:0]  bus_addr_i;
  logic [15:0] bus_wdata_i;
  logic [15:0] bus_rdata_o;
  logic        rst_req_o;

  int checks = 0;
  int errors = 0;
  int tick_total = 0;
  int pulses = 0;
  bit done = 0;
  int exp_q[$];

  keyed_wdt #(.SYNC_TICKS(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_sel_i(bus_sel_i),
    .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .rst_req_o(rst_req_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected expiry tick numbers as pulses appear
  always @(negedge clk) begin
    #1;
    if (rst_n && rst_req_o) begin
      pulses++;
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected request actual=%0d expected=none", tick_total);
      end else begin
        check("R5/R10 expiry tick", tick_total, exp_q.pop_front());
      end
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_sel_i = 0; bus_we_i = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output int v);
    @(negedge clk);
    bus_sel_i = 1; bus_we_i = 0; bus_addr_i = a;
    #2 v = int'(bus_rdata_o);
    bus_sel_i = 0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1; tick_total++;
      @(negedge clk); tick_i = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  function automatic int div_of(input int code);
    return (code >= 6) ? 256 : (4 << code);
  endfunction

  task automatic flush_queue(input string tag);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s missing requests actual=%0d expected=0", tag, exp_q.size());
      exp_q.delete();
    end
  endtask

  // driver: configure, start, push expected expiries, run ticks
  task automatic run_case(input int code, input int rl, input int periods);
    int v, n, base;
    do_reset();
    bus_wr(0, 16'h5555);
    bus_wr(1, 16'(code)); tick(2);
    bus_wr(2, 16'(rl));   tick(2);
    bus_rd(1, v); check("R4 divider readback", v, code);
    bus_rd(2, v); check("R4 reload readback", v, rl);
    bus_wr(0, 16'hCCCC);
    base = tick_total;
    // R8: keys after start do not stop or shift the timer
    bus_wr(0, 16'h0000);
    bus_wr(0, 16'h1234);
    bus_wr(0, 16'hCCCC);
    bus_wr(0, 16'h5555);
    n = ((rl == 0) ? 1 : rl) * div_of(code);
    for (int p = 1; p <= periods; p++) exp_q.push_back(base + p * n);
    tick(periods * n + 1);
    flush_queue("R6/R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, p0;
    rst_n = 0; tick_i = 0; bus_sel_i = 0; bus_we_i = 0;
    bus_addr_i = 0; bus_wdata_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 rst_req", int'(rst_req_o), 0);
    bus_rd(3, v); check("R1 status", v, 0);
    bus_rd(1, v); check("R1 divider", v, 0);
    bus_rd(2, v); check("R1 reload", v, 'hFFF);
    bus_wr(0, 16'h5555);
    bus_rd(0, v); check("R1 key reads zero", v, 0);
    bus_wr(0, 16'h0000);

    // R2 locked writes dropped
    bus_wr(1, 16'h0003);
    bus_rd(3, v); check("R2 status after locked write", v, 0);
    tick(3);
    bus_rd(1, v); check("R2 divider unchanged", v, 0);

    // R9 unknown key leaves it locked
    bus_wr(0, 16'h1234);
    bus_wr(2, 16'h0010);
    bus_rd(3, v); check("R9 status after 0x1234", v, 0);

    // R3/R4 unlocked updates with busy timing
    bus_wr(0, 16'h5555);
    bus_wr(2, 16'h0005);
    bus_rd(3, v); check("R3 reload busy", v, 2);
    tick(1);
    bus_rd(3, v); check("R4 busy after 1 tick", v, 2);
    tick(1);
    bus_rd(3, v); check("R4 busy cleared", v, 0);
    bus_rd(2, v); check("R4 reload applied", v, 5);
    bus_wr(1, 16'h0007);
    bus_rd(3, v); check("R3 divider busy", v, 1);
    tick(2);
    bus_rd(1, v); check("R4 divider applied", v, 7);
    bus_wr(2, 16'h0FFF); tick(2);
    bus_rd(2, v); check("R4 reload max", v, 'hFFF);

    // R2 relock then drop
    bus_wr(0, 16'h0000);
    bus_wr(2, 16'h0002);
    bus_rd(3, v); check("R2 relocked status", v, 0);
    tick(2);
    bus_rd(2, v); check("R2 relocked reload", v, 'hFFF);

    // R11 no request before start
    p0 = pulses;
    tick(40);
    check("R11 idle pulses", pulses - p0, 0);

    // R5/R6/R10 divider codes, periodic expiry
    run_case(0, 3, 3);
    run_case(1, 2, 1);
    run_case(2, 2, 1);
    run_case(5, 1, 1);
    run_case(6, 1, 1);
    run_case(7, 1, 1);
    run_case(0, 0, 2);   // R5 reload 0 boundary

    // R7 refresh
    do_reset();
    bus_wr(0, 16'h5555);
    bus_wr(2, 16'h0004); tick(2);
    bus_wr(0, 16'hCCCC);
    tick(10);
    bus_wr(0, 16'hAAAA);
    exp_q.push_back(tick_total + 16);
    tick(17);
    flush_queue("R7");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule